// File: doc/BRIEF.md
# Parameter Block Fetch and Dispatch Sequencer

This block sits behind the host-facing register logic of a diskette subsystem. When the host has written the 16-bit address of a parameter block and fired the launch pulse, the sequencer reads the eight-byte block out of system memory through a byte-wide read port. It reads one byte at a time, in ascending address order, and never has more than one read outstanding. It then checks the channel and instruction bytes.

When the block is well formed, the sequencer hands one of seven real disk operations to a downstream engine in a single-cycle command strobe, then waits for the engine's response. A no-op, a malformed block or a drive that is not ready ends the operation at once with a result byte. Every operation ends with a one-cycle completion pulse that carries a result byte. The completion interrupt is raised or withheld according to the interrupt field of the channel byte.

Top module: `pblock_sequencer`

## Requirements
- R1: After reset the block is idle: busy, mem_rd_req, cmd_valid, done and irq are all low.
- R2: After launch the block reads offsets 0 to 7 from the latched base address, in ascending order. It issues a one-cycle mem_rd_req for each byte and issues the next request only after mem_rd_valid has returned the previous byte.
- R3: A launch pulse that arrives while the block is busy is ignored. The current fetch addresses are unchanged and no second operation follows.
- R4: If channel byte bits 5:4 hold 10 or 11 (illegal interrupt codes), the block completes with result byte 0x08 (bit 3, address error) and dispatches nothing.
- R5: If instruction byte bits 7:6 are not zero, the block completes with result byte 0x08 and dispatches nothing.
- R6: If channel byte bit 3 and instruction byte bit 3 (word length, 0 = 8-bit, 1 = 16-bit) differ, the block completes with result byte 0x08 and dispatches nothing. The checks of R4 to R6 come before all other checks.
- R7: An opcode of 000 (instruction bits 2:0) completes with result byte 0x00 and no dispatch, whatever the drive readiness.
- R8: If the drive selected by instruction bits 5:4 has its drive_ready bit low, the block completes with result byte 0x80 (bit 7, not ready) and dispatches nothing.
- R9: Any other opcode produces exactly one cycle of cmd_valid. During that cycle cmd_op carries instruction bits 2:0 and cmd_drive carries instruction bits 5:4. cmd_count carries byte 2, cmd_track byte 4 and cmd_sector byte 5. cmd_buf carries {byte 7, byte 6}, cmd_wide carries channel bit 3 and cmd_rand_fmt carries channel bit 6.
- R10: After a dispatch the block waits for eng_done. It then gives one done pulse, with result byte eng_status if eng_err is high and 0x00 if it is low, and returns to idle on the next cycle.
- R11: irq pulses together with done only when channel bits 5:4 are 00. It stays low for code 01 and for the illegal codes.
- R12: Fetch addresses wrap modulo 2^16, so a block at 0xFFFC continues at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| launch | input | 1 | Start pulse from the host register logic |
| blk_addr | input | 16 | Parameter block base address, sampled on launch |
| mem_rd_req | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 8 | Read data |
| drive_ready | input | 4 | Ready flag for each drive |
| cmd_valid | output | 1 | One-cycle dispatch strobe |
| cmd_op | output | 3 | Operation code |
| cmd_drive | output | 2 | Selected drive |
| cmd_count | output | 8 | Record count |
| cmd_track | output | 8 | Track address |
| cmd_sector | output | 8 | Sector address |
| cmd_buf | output | 16 | Buffer address |
| cmd_wide | output | 1 | 16-bit data words |
| cmd_rand_fmt | output | 1 | Random format sequence requested |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine reports an error |
| eng_status | input | 8 | Engine error bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_byte | output | 8 | Result byte, valid with done |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The assertions assume that the memory raises mem_rd_valid only for a request it has accepted, and never more than once per request. They also assume that eng_done arrives only after a dispatch. The bench responders follow both rules by design. Each one starts a latency countdown when it sees the request or the strobe, and returns exactly one pulse when the countdown reaches zero. The latencies vary from test to test. During one long fetch a second launch is injected on purpose.

// File: rtl/pblock_sequencer.sv
`timescale 1ns/1ps
module pblock_sequencer #(
  parameter int ADDR_W = 16,
  parameter logic [7:0] ERR_BAD_BLOCK = 8'h08,
  parameter logic [7:0] ERR_NOT_READY = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] blk_addr,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [7:0]        mem_rd_data,
  input  logic [3:0]        drive_ready,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [1:0]        cmd_drive,
  output logic [7:0]        cmd_count,
  output logic [7:0]        cmd_track,
  output logic [7:0]        cmd_sector,
  output logic [15:0]       cmd_buf,
  output logic              cmd_wide,
  output logic              cmd_rand_fmt,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic [7:0]        eng_status,
  output logic              busy,
  output logic              done,
  output logic [7:0]        res_byte,
  output logic              irq
);
  localparam int NBYTES = 8;
  localparam int IDX_W  = $clog2(NBYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_CHECK, S_SEND, S_ENG, S_FIN} state_t;

  state_t            st;
  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        blk [NBYTES];
  logic [7:0]        res;
  logic              bad;

  assign bad = blk[0][5] | (|blk[1][7:6]) | (blk[0][3] ^ blk[1][3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      base <= '0;
      idx  <= '0;
      res  <= '0;
      for (int i = 0; i < NBYTES; i++) blk[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (launch) begin
          base <= blk_addr;
          idx  <= '0;
          st   <= S_REQ;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (mem_rd_valid) begin
          blk[idx] <= mem_rd_data;
          if (idx == LAST) st <= S_CHECK;
          else begin
            idx <= idx + 1'b1;
            st  <= S_REQ;
          end
        end
        S_CHECK: begin
          if (bad) begin
            res <= ERR_BAD_BLOCK;
            st  <= S_FIN;
          end else if (blk[1][2:0] == 3'b000) begin
            res <= 8'h00;
            st  <= S_FIN;
          end else if (!drive_ready[blk[1][5:4]]) begin
            res <= ERR_NOT_READY;
            st  <= S_FIN;
          end else begin
            st <= S_SEND;
          end
        end
        S_SEND: st <= S_ENG;
        S_ENG: if (eng_done) begin
          res <= eng_err ? eng_status : 8'h00;
          st  <= S_FIN;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd_req   = (st == S_REQ);
  assign mem_rd_addr  = base + ADDR_W'(idx);
  assign cmd_valid    = (st == S_SEND);
  assign cmd_op       = blk[1][2:0];
  assign cmd_drive    = blk[1][5:4];
  assign cmd_count    = blk[2];
  assign cmd_track    = blk[4];
  assign cmd_sector   = blk[5];
  assign cmd_buf      = {blk[7], blk[6]};
  assign cmd_wide     = blk[0][3];
  assign cmd_rand_fmt = blk[0][6];
  assign busy         = (st != S_IDLE);
  assign done         = (st == S_FIN);
  assign res_byte     = res;
  assign irq          = done & (blk[0][5:4] == 2'b00);

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req); // R2
  AST_NO_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !mem_rd_valid) |=> !mem_rd_req); // R2
  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(base)); // R3
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R10
  AST_IRQ_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R11
endmodule

// File: tb/pblock_sequencer_test.sv
`timescale 1ns/1ps
module pblock_sequencer_test;
  logic        clk = 1'b0, rst_n = 1'b0, launch = 1'b0;
  logic [15:0] blk_addr = '0;
  logic        mem_rd_req, mem_rd_valid = 1'b0;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = '0;
  logic [3:0]  drive_ready = 4'hF;
  logic        cmd_valid, cmd_wide, cmd_rand_fmt;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_drive;
  logic [7:0]  cmd_count, cmd_track, cmd_sector;
  logic [15:0] cmd_buf;
  logic        eng_done = 1'b0, eng_err = 1'b0;
  logic [7:0]  eng_status = '0;
  logic        busy, done, irq;
  logic [7:0]  res_byte;

  pblock_sequencer uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0]  img [8];
  logic [15:0] cur_base = '0;
  int          mlat = 1, elat = 1;
  logic        eerr = 1'b0;
  logic [7:0]  ecode = '0;
  bit          relaunch = 0;
  logic [15:0] exp_addr [$];
  bit          exp_disp = 0, exp_irq = 0;
  logic [7:0]  exp_res = '0;
  string       exp_tag = "";
  int          n_done = 0, n_disp = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory responder: one valid per request after mlat cycles
  logic [15:0] raddr = '0;
  int mcnt = 0;
  always @(negedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_req) begin
      raddr = mem_rd_addr;
      mcnt  = mlat;
    end else if (mcnt > 0) begin
      mcnt--;
      if (mcnt == 0) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= img[raddr[2:0] - cur_base[2:0]];
      end
    end
  end

  // engine responder
  int ecnt = 0;
  always @(negedge clk) begin
    eng_done <= 1'b0;
    if (cmd_valid) ecnt = elat;
    else if (ecnt > 0) begin
      ecnt--;
      if (ecnt == 0) begin
        eng_done   <= 1'b1;
        eng_err    <= eerr;
        eng_status <= ecode;
      end
    end
  end

  // per-cycle reference comparison
  always @(negedge clk) if (rst_n) begin
    if (mem_rd_req) begin
      if (exp_addr.size() == 0) chk(0, "R2 unexpected read", mem_rd_addr, 0);
      else begin
        logic [15:0] e;
        e = exp_addr.pop_front();
        chk(mem_rd_addr == e, "R2 read address", mem_rd_addr, e);
      end
    end
    if (cmd_valid) begin
      n_disp++;
      chk(exp_disp, {exp_tag, " unexpected dispatch"}, 1, 0);
      chk(cmd_op == img[1][2:0], "R9 op", cmd_op, img[1][2:0]);
      chk(cmd_drive == img[1][5:4], "R9 drive", cmd_drive, img[1][5:4]);
      chk(cmd_count == img[2], "R9 count", cmd_count, img[2]);
      chk(cmd_track == img[4], "R9 track", cmd_track, img[4]);
      chk(cmd_sector == img[5], "R9 sector", cmd_sector, img[5]);
      chk(cmd_buf == {img[7], img[6]}, "R9 buffer", cmd_buf, {img[7], img[6]});
      chk(cmd_wide == img[0][3], "R9 wide", cmd_wide, img[0][3]);
      chk(cmd_rand_fmt == img[0][6], "R9 rand", cmd_rand_fmt, img[0][6]);
    end
    if (done) begin
      n_done++;
      chk(res_byte == exp_res, exp_tag, res_byte, exp_res);
      chk(irq == exp_irq, "R11 irq", irq, exp_irq);
    end else if (irq) chk(0, "R11 irq without done", 1, 0);
  end

  task automatic run_op(input logic [15:0] base, input string tag);
    logic [7:0] ch, ins;
    bit bad;
    int d0, p0;
    ch  = img[0];
    ins = img[1];
    bad = ch[5] || (ins[7:6] != 2'b00) || (ch[3] != ins[3]);
    cur_base = base;
    exp_addr.delete();
    for (int i = 0; i < 8; i++) exp_addr.push_back(base + 16'(i));
    exp_irq  = (ch[5:4] == 2'b00);
    exp_disp = 0;
    if (bad) exp_res = 8'h08;
    else if (ins[2:0] == 3'b000) exp_res = 8'h00;
    else if (!drive_ready[ins[5:4]]) exp_res = 8'h80;
    else begin
      exp_disp = 1;
      exp_res  = eerr ? ecode : 8'h00;
    end
    exp_tag = tag;
    d0 = n_done;
    p0 = n_disp;
    @(negedge clk); launch = 1'b1; blk_addr = base;
    @(negedge clk); launch = 1'b0;
    if (relaunch) begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b1, "R3 busy during fetch", busy, 1);
      launch = 1'b1; blk_addr = base + 16'h0040;
      @(negedge clk); launch = 1'b0;
    end
    for (int k = 0; k < 3000 && n_done == d0; k++) @(posedge clk);
    repeat (12) @(negedge clk);
    chk(n_done == d0 + 1, {tag, " one completion"}, n_done - d0, 1);
    chk((n_disp - p0) == int'(exp_disp), {tag, " dispatch count"}, n_disp - p0, exp_disp);
    chk(exp_addr.size() == 0, "R2 all bytes fetched", exp_addr.size(), 0);
    chk(busy == 1'b0, "R10 idle after done", busy, 0);
  endtask

  task automatic set_img(input logic [7:0] b0, b1, b2, b4, b5, b6, b7);
    img[0] = b0; img[1] = b1; img[2] = b2; img[3] = 8'hA5;
    img[4] = b4; img[5] = b5; img[6] = b6; img[7] = b7;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && mem_rd_req == 0 && cmd_valid == 0 && done == 0 && irq == 0,
        "R1 reset outputs", {busy, mem_rd_req, cmd_valid, done, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1 idle after reset", busy, 0);

    // read data, drive 1, 8-bit, interrupt on
    drive_ready = 4'b0010; mlat = 1; elat = 2; eerr = 0;
    set_img(8'h00, 8'h14, 8'h03, 8'h22, 8'h07, 8'h00, 8'h80);
    run_op(16'h1000, "R10 read ok");

    // write deleted, 16-bit, interrupts off, random format, engine error
    drive_ready = 4'b1111; mlat = 3; elat = 5; eerr = 1; ecode = 8'h42;
    set_img(8'h58, 8'h2F, 8'h10, 8'h4C, 8'h1A, 8'h34, 8'h12);
    run_op(16'h2345, "R10 engine error");

    // format track on drive 3 with a second launch during the fetch
    eerr = 0; mlat = 5; relaunch = 1;
    set_img(8'h40, 8'h32, 8'h1A, 8'h05, 8'h01, 8'hEF, 8'hBE);
    run_op(16'h3000, "R3 relaunch ignored");
    relaunch = 0; mlat = 2;

    set_img(8'h20, 8'h04, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00);
    run_op(16'h4000, "R4 illegal code 10");
    set_img(8'h30, 8'h04, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00);
    run_op(16'h4100, "R4 illegal code 11");
    set_img(8'h00, 8'h44, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00);
    run_op(16'h4200, "R5 reserved bits");
    set_img(8'h08, 8'h04, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00);
    run_op(16'h4300, "R6 word length mismatch");

    drive_ready = 4'b0000;
    set_img(8'h00, 8'h30, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00);
    run_op(16'h5000, "R7 no-op");
    drive_ready = 4'b1011;
    set_img(8'h10, 8'h26, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00);
    run_op(16'h5100, "R8 not ready");

    drive_ready = 4'b0001; elat = 1;
    set_img(8'h00, 8'h01, 8'h00, 8'h30, 8'h00, 8'h00, 8'h00);
    run_op(16'hFFFC, "R12 wrap seek");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule